// File: doc/BRIEF.md
# Lock-Protected Cycle Counter

This block is a small memory-mapped peripheral that counts clock cycles for profiling code. Software uses a single-cycle 32-bit register port with a 12-bit byte offset to reach four locations: a control word, a 32-bit cycle tally, a key register and a lock state register. Bit 0 of the control word starts and stops the tally. Bit 30 of the control word is a read-only constant 1. The tally can be preset or cleared at any time by writing it.

A software lock guards the control word. The block comes out of reset locked, and control writes are dropped until the 32-bit key 0xC5ACCE55 is written to the key register. Any other value written there locks the block again, and writing 0 is the usual way to do so. An external trace-enable input acts as a master gate. While it is low, every location reads as zero, writes are discarded and the tally stays frozen.

Read data is registered. A read presented in one cycle returns its value on `bus_rdata` in the next cycle. The value reflects the state just before the clock edge that samples the read. In any cycle that follows no read, `bus_rdata` is zero.

Top module: `cyc_meter_top`

## Requirements
- R1: After synchronous reset, with trace enabled, the locations read as follows: control (offset 0x000) reads 0x40000000, tally (0x004) reads 0, lock state (0xFB4) reads 0x3 and the key register (0xFB0) reads 0.
- R2: While `trace_en` is low, every read returns 0x00000000, every write is discarded and the tally does not change.
- R3: Writing 0xC5ACCE55 to offset 0xFB0 unlocks the block from the next cycle on, and the lock state then reads 0x1. In the lock state word, bit 0 is a constant 1 and bit 1 is 1 while the block is locked.
- R4: Writing any other value to offset 0xFB0, including 0, leaves the block locked or locks it again, so the lock state reads 0x3.
- R5: While the block is locked, writes to the control word are ignored and the word keeps its previous value.
- R6: Control bit 0 is the only writable control bit. When it is 1 the tally rises by one on every clock, and when it is 0 the tally holds. Control bit 30 always reads 1 and all other control bits read 0.
- R7: A write to offset 0x004 loads the tally whether the block is locked or not. A load takes priority over the increment in the same cycle.
- R8: The tally wraps from 0xFFFFFFFF to 0 without raising any flag.
- R9: The key register reads 0. Unmapped offsets read 0, and writes to them change nothing.
- R10: Read data appears exactly one cycle after the read strobe. `bus_rdata` is 0 in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trace_en | input | 1 | Master gate for reads, writes and counting |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The bench first writes the control word while the block is locked. A design that leaked such writes would start counting, and the next tally read would no longer match. It then writes the tally after enabling counting, at the exact cycle where a wrong priority between load and increment would show as an off-by-one. The tally is also preset near the top of its range to expose a design that saturates or stalls instead of wrapping. Finally, the bench relocks with a value other than the key, and drops trace enable around a tally write, to catch a design that still accepts writes or shows nonzero data while gated.

// File: rtl/cyc_meter_pkg.sv
package cyc_meter_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_TALLY = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_KEY   = 12'hFB0;
  localparam logic [ADDR_W-1:0] OFS_LSTAT = 12'hFB4;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'hC5AC_CE55;
  localparam int unsigned CTRL_FIXED_BIT = 30;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_TALLY,
    SEL_KEY,
    SEL_LSTAT
  } reg_sel_e;
endpackage

// File: rtl/cm_lock_fsm.sv
module cm_lock_fsm
  import cyc_meter_pkg::*;
#(
  parameter int unsigned W = DATA_W,
  parameter logic [W-1:0] KEY = UNLOCK_KEY
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         key_wr,
  input  logic [W-1:0] key_val,
  output logic         locked
);
  typedef enum logic {ST_LOCKED, ST_OPEN} lock_st_e;
  lock_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (key_wr) st_d = (key_val == KEY) ? ST_OPEN : ST_LOCKED;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_LOCKED;
    else     st_q <= st_d;
  end

  assign locked = (st_q == ST_LOCKED);
endmodule

// File: rtl/cm_ctrl_reg.sv
module cm_ctrl_reg (
  input  logic clk,
  input  logic rst,
  input  logic ctrl_wr,
  input  logic locked,
  input  logic wr_bit0,
  output logic run_en
);
  always_ff @(posedge clk) begin
    if (rst)                    run_en <= 1'b0;
    else if (ctrl_wr && !locked) run_en <= wr_bit0;
  end
endmodule

// File: rtl/cm_tally.sv
module cm_tally #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] tally
);
  always_ff @(posedge clk) begin
    if (rst)       tally <= '0;
    else if (load) tally <= load_val;
    else if (step) tally <= tally + W'(1);
  end
endmodule

// File: rtl/cm_read_port.sv
module cm_read_port
  import cyc_meter_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_ok,
  input  reg_sel_e     sel,
  input  logic         run_en,
  input  logic         locked,
  input  logic [W-1:0] tally,
  output logic [W-1:0] rdata
);
  logic [W-1:0] val;

  always_comb begin
    val = '0;
    case (sel)
      SEL_CTRL: begin
        val[CTRL_FIXED_BIT] = 1'b1;
        val[0]              = run_en;
      end
      SEL_TALLY: val = tally;
      SEL_LSTAT: begin
        val[0] = 1'b1;
        val[1] = locked;
      end
      default: val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_ok) rdata <= val;
    else            rdata <= '0;
  end
endmodule

// File: rtl/cyc_meter_top.sv
module cyc_meter_top
  import cyc_meter_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              trace_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  reg_sel_e          sel;
  logic              wr_ok, rd_ok;
  logic              lock_q, run_en;
  logic [DATA_W-1:0] tally_q;

  always_comb begin
    case (bus_addr)
      OFS_CTRL:  sel = SEL_CTRL;
      OFS_TALLY: sel = SEL_TALLY;
      OFS_KEY:   sel = SEL_KEY;
      OFS_LSTAT: sel = SEL_LSTAT;
      default:   sel = SEL_NONE;
    endcase
  end

  assign wr_ok = bus_wr & trace_en;
  assign rd_ok = bus_rd & trace_en;

  cm_lock_fsm #(.W(DATA_W), .KEY(UNLOCK_KEY)) u_lock (
    .clk     (clk),
    .rst     (rst),
    .key_wr  (wr_ok && sel == SEL_KEY),
    .key_val (bus_wdata),
    .locked  (lock_q)
  );

  cm_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .ctrl_wr (wr_ok && sel == SEL_CTRL),
    .locked  (lock_q),
    .wr_bit0 (bus_wdata[0]),
    .run_en  (run_en)
  );

  cm_tally #(.W(DATA_W)) u_tally (
    .clk      (clk),
    .rst      (rst),
    .step     (run_en & trace_en),
    .load     (wr_ok && sel == SEL_TALLY),
    .load_val (bus_wdata),
    .tally    (tally_q)
  );

  cm_read_port #(.W(DATA_W)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd_ok  (rd_ok),
    .sel    (sel),
    .run_en (run_en),
    .locked (lock_q),
    .tally  (tally_q),
    .rdata  (bus_rdata)
  );
endmodule

// File: rtl/cm_checker.sv
module cm_checker
  import cyc_meter_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              trace_en,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              locked,
  input logic              run_en,
  input logic [DATA_W-1:0] tally
);
  a_r3_key_opens: assert property (@(posedge clk) disable iff (rst)
    (trace_en && bus_wr && bus_addr == OFS_KEY && bus_wdata == UNLOCK_KEY) |=> !locked);

  a_r4_other_locks: assert property (@(posedge clk) disable iff (rst)
    (trace_en && bus_wr && bus_addr == OFS_KEY && bus_wdata != UNLOCK_KEY) |=> locked);

  a_r5_locked_hold: assert property (@(posedge clk) disable iff (rst)
    (locked && bus_wr && bus_addr == OFS_CTRL) |=> $stable(run_en));

  a_r6_step: assert property (@(posedge clk) disable iff (rst)
    (run_en && trace_en && !(bus_wr && bus_addr == OFS_TALLY)) |=> tally == $past(tally) + 32'd1);

  a_r2_frozen: assert property (@(posedge clk) disable iff (rst)
    !trace_en |=> $stable(tally));

  a_r2_zero_read: assert property (@(posedge clk) disable iff (rst)
    !trace_en |=> bus_rdata == '0);

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == '0);
endmodule

bind cyc_meter_top cm_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .trace_en  (trace_en),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .locked    (lock_q),
  .run_en    (run_en),
  .tally     (tally_q)
);

// File: tb/tb_cyc_meter_top.sv
module tb_cyc_meter_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trace_en = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  cyc_meter_top dut (
    .clk(clk), .rst(rst), .trace_en(trace_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // Tasks start and end at a falling edge; the rising edge between is the action edge.
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // Monitor: a read seen at a rising edge is compared at the following falling edge.
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          n_chk++; n_err++;
          $display("FAIL monitor: unexpected read data %h", bus_rdata);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          n_chk++;
          if (bus_rdata !== e) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(12'h000, 32'h4000_0000, "R1 ctrl");
    rd(12'h004, 32'h0, "R1 tally");
    rd(12'hFB4, 32'h3, "R1 lstat");
    rd(12'hFB0, 32'h0, "R1 key");
    // R10 idle output is zero
    @(negedge clk);
    n_chk++;
    if (bus_rdata !== 32'h0) begin
      n_err++; $display("FAIL R10: got %h expected %h", bus_rdata, 32'h0);
    end

    // R5 locked control write ignored
    wr(12'h000, 32'h0000_0001);
    rd(12'h000, 32'h4000_0000, "R5 ctrl");
    rd(12'h004, 32'h0, "R5 tally");

    // R9 unmapped
    wr(12'h010, 32'hDEAD_BEEF);
    rd(12'h010, 32'h0, "R9 unmapped");
    rd(12'h008, 32'h0, "R9 unmapped2");

    // R7 tally load while locked
    wr(12'h004, 32'h55);
    rd(12'h004, 32'h55, "R7 locked load");

    // R3 unlock
    wr(12'hFB0, 32'hC5AC_CE55);
    rd(12'hFB4, 32'h1, "R3 lstat");

    // R6 enable: only bit0 kept
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, 32'h4000_0001, "R6 ctrl");
    // R7 load wins over increment
    wr(12'h004, 32'd100);
    rd(12'h004, 32'd100, "R7 load priority");
    rd(12'h004, 32'd101, "R6 step1");
    rd(12'h004, 32'd102, "R6 step2");

    // R8 wrap
    wr(12'h004, 32'hFFFF_FFFE);
    rd(12'h004, 32'hFFFF_FFFE, "R8 pre");
    rd(12'h004, 32'hFFFF_FFFF, "R8 top");
    rd(12'h004, 32'h0, "R8 wrap");
    rd(12'h004, 32'h1, "R8 after");

    // R4 relock with non-key value
    wr(12'hFB0, 32'h1234_5678);
    rd(12'hFB4, 32'h3, "R4 junk relock");
    wr(12'h000, 32'h0);
    rd(12'h000, 32'h4000_0001, "R5 relocked ctrl");
    wr(12'hFB0, 32'hC5AC_CE55);
    wr(12'h000, 32'h0);
    wr(12'h004, 32'h777);
    wr(12'hFB0, 32'h0);
    rd(12'hFB4, 32'h3, "R4 zero relock");
    rd(12'h004, 32'h777, "R6 hold");

    // R2 trace gate
    trace_en = 1'b0;
    wr(12'h004, 32'h5);
    rd(12'h000, 32'h0, "R2 ctrl");
    rd(12'hFB4, 32'h0, "R2 lstat");
    rd(12'h004, 32'h0, "R2 tally");
    trace_en = 1'b1;
    rd(12'h004, 32'h777, "R2 write dropped");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL monitor: got %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule